// File: doc/BRIEF.md
# Five-Stage Pipelined Load-Store Datapath

This block is a compact in-order processor core. Instructions move through fetch, decode with register read, ALU execute, data-memory access and register writeback. Each stage hands the next one a registered record of everything later stages need: the effective opcode, both destination fields, operand values, offset, PC+1 and a computed branch target. No stage decodes control centrally. The core runs add, nand, load word and store word on eight 32-bit registers. Instruction and data storage are small internal arrays. A load port, accepted only while reset is held, fills them.

No hazard is detected, forwarded or stalled, so programs keep a producer and its consumer at least three instructions apart. A dedicated halt word stops fetch and drains the pipe. A status pin then reports that every earlier instruction has retired. A combinational debug port reads any register.

Instruction word layout: bits 31..25 reserved (must be zero), opcode in 24..22, field A in 21..19, field B in 18..16, a 16-bit two's-complement offset in 15..0, and the register-register destination in 2..0.

Top module: `pipe5_core`

## Requirements
- R1: While reset is held and after its release until writeback starts, every register reads zero and `halted` is low; the pipeline starts filled with all-zero words that change no visible state.
- R2: Opcode 0 (add) writes the sum of the registers named in bits 21..19 and 18..16 into the register named by bits 2..0, wrapping modulo 2^32.
- R3: Opcode 1 (nand) writes the bitwise inverse of the AND of the two source registers into the register named by bits 2..0.
- R4: Opcode 2 (load) reads data word (register[bits 21..19] + sign-extended bits 15..0) and writes it into the register named by bits 18..16.
- R5: Opcode 3 (store) writes register[bits 18..16] to data word (register[bits 21..19] + sign-extended offset) and writes no register.
- R6: Register 0 always reads zero; writes to it from any opcode are dropped.
- R7: A register written in writeback is returned to a decode read of the same register in that same cycle.
- R8: One instruction is fetched per clock edge, starting at address 0. Instruction i, counted from 0, has its register result visible after clock edge i+5, where edge 1 is the first edge after reset release.
- R9: Opcode 6 with zero reserved bits (halt) freezes the PC. No later word executes. With the halt at index H, `halted` rises after edge H+5 and stays high until reset.
- R10: Writes on the load port (`boot_dmem` 1 = data array, 0 = instruction array) take effect only while `rst_n` is low; with `rst_n` high they are ignored.
- R11: A load from a data address at or beyond the array depth returns zero; a store to such an address is dropped.
- R12: A word with any nonzero reserved bit, or with opcode 4, 5 or 7, executes as a no-operation and changes no register or memory word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset; also enables the load port |
| boot_we | input | 1 | Load-port write strobe |
| boot_dmem | input | 1 | Load-port target: 1 data array, 0 instruction array |
| boot_addr | input | 32 | Load-port word address |
| boot_data | input | 32 | Load-port write data |
| dbg_addr | input | 3 | Register number for the debug read |
| dbg_data | output | 32 | Current value of the register at `dbg_addr` |
| halted | output | 1 | High once a halt word has drained through the pipe |

## Verification
The assertions check on every cycle:
- the PC steps by one until a halt is fetched and is frozen after it;
- `halted` is sticky;
- a store never raises the register write enable;
- a load writes the field-B register;
- the carried branch target tracks PC+1 plus the offset;
- register 0 stays zero.

Arithmetic results, the field-dependent load and store addressing, the writeback-to-decode pass-through, out-of-range data addresses, reserved encodings and the load port being ignored outside reset are shown only by the bench. It runs two programs, compares every register and `halted` after each edge against a behavioural model, and spot-checks the final values against hand-computed constants.

// File: rtl/pipe5_pkg.sv
`timescale 1ns/1ps
package pipe5_pkg;
    localparam int XLEN    = 32;
    localparam int ILEN    = 32;
    localparam int PCW     = 16;
    localparam int OPW     = 3;
    localparam int RIDW    = 3;
    localparam int OFFW    = 16;
    localparam int OP_LSB  = 22;
    localparam int RA_LSB  = 19;
    localparam int RB_LSB  = 16;
    localparam int RD_LSB  = 0;
    localparam int RSV_LSB = 25;

    localparam logic [OPW-1:0] OP_ADD  = 3'd0;
    localparam logic [OPW-1:0] OP_NAND = 3'd1;
    localparam logic [OPW-1:0] OP_LW   = 3'd2;
    localparam logic [OPW-1:0] OP_SW   = 3'd3;
    localparam logic [OPW-1:0] OP_HALT = 3'd6;
    localparam logic [OPW-1:0] OP_NOP  = 3'd7;

    // Effective opcode: reserved bits or unassigned codes collapse to a no-op.
    function automatic logic [OPW-1:0] eff_op(input logic [ILEN-1:0] word);
        logic [OPW-1:0] raw;
        raw = word[OP_LSB +: OPW];
        if (word[ILEN-1:RSV_LSB] != '0) begin
            return OP_NOP;
        end
        case (raw)
            OP_ADD, OP_NAND, OP_LW, OP_SW, OP_HALT: return raw;
            default:                               return OP_NOP;
        endcase
    endfunction

    typedef struct packed {
        logic [ILEN-1:0] instr;
        logic [PCW-1:0]  pc1;
    } fd_rec_t;

    typedef struct packed {
        logic [OPW-1:0]  op;
        logic [XLEN-1:0] va;
        logic [XLEN-1:0] vb;
        logic [XLEN-1:0] off;
        logic [RIDW-1:0] dst_rr;
        logic [RIDW-1:0] dst_ld;
        logic [PCW-1:0]  pc1;
    } dx_rec_t;

    typedef struct packed {
        logic [OPW-1:0]  op;
        logic [XLEN-1:0] alu;
        logic [XLEN-1:0] vb;
        logic [PCW-1:0]  target;
        logic [RIDW-1:0] dst_rr;
        logic [RIDW-1:0] dst_ld;
    } xm_rec_t;

    typedef struct packed {
        logic [OPW-1:0]  op;
        logic [XLEN-1:0] alu;
        logic [XLEN-1:0] mdata;
        logic [RIDW-1:0] dst_rr;
        logic [RIDW-1:0] dst_ld;
    } mw_rec_t;

    typedef struct packed {
        logic [PCW-1:0] pc;
        logic           halt_seen;
        logic           halted;
        fd_rec_t        fd;
        dx_rec_t        dx;
        xm_rec_t        xm;
        mw_rec_t        mw;
    } core_state_t;
endpackage

// File: rtl/pipe5_regfile.sv
`timescale 1ns/1ps
module pipe5_regfile #(
    parameter int XLEN = 32,
    parameter int NREG = 8,
    localparam int RW  = $clog2(NREG)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [RW-1:0]   rd_a_addr,
    output logic [XLEN-1:0] rd_a_data,
    input  logic [RW-1:0]   rd_b_addr,
    output logic [XLEN-1:0] rd_b_data,
    input  logic            wr_en,
    input  logic [RW-1:0]   wr_addr,
    input  logic [XLEN-1:0] wr_data,
    input  logic [RW-1:0]   dbg_addr,
    output logic [XLEN-1:0] dbg_data
);
    logic [XLEN-1:0] regs_d [NREG];
    logic [XLEN-1:0] regs_q [NREG];
    logic            wr_live;

    assign wr_live = wr_en && (wr_addr != '0);

    always_comb begin
        for (int i = 0; i < NREG; i++) begin
            regs_d[i] = regs_q[i];
        end
        if (wr_live) begin
            regs_d[wr_addr] = wr_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NREG; i++) begin
                regs_q[i] <= '0;
            end
        end else begin
            for (int i = 0; i < NREG; i++) begin
                regs_q[i] <= regs_d[i];
            end
        end
    end

    // Same-cycle pass-through of the writeback value to decode reads.
    assign rd_a_data = (wr_live && wr_addr == rd_a_addr) ? wr_data : regs_q[rd_a_addr];
    assign rd_b_data = (wr_live && wr_addr == rd_b_addr) ? wr_data : regs_q[rd_b_addr];
    assign dbg_data  = regs_q[dbg_addr];

    p_r0_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
        regs_q[0] == '0);
endmodule

// File: rtl/pipe5_alu.sv
`timescale 1ns/1ps
module pipe5_alu
    import pipe5_pkg::*;
#(
    parameter int W = 32
) (
    input  logic [OPW-1:0] op,
    input  logic [W-1:0]   opa,
    input  logic [W-1:0]   opb,
    output logic [W-1:0]   res
);
    always_comb begin
        case (op)
            OP_ADD:       res = opa + opb;
            OP_NAND:      res = ~(opa & opb);
            OP_LW, OP_SW: res = opa + opb;
            default:      res = '0;
        endcase
    end
endmodule

// File: rtl/pipe5_dmem.sv
`timescale 1ns/1ps
module pipe5_dmem #(
    parameter int XLEN  = 32,
    parameter int DEPTH = 64,
    localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            boot_we,
    input  logic [XLEN-1:0] boot_addr,
    input  logic [XLEN-1:0] boot_data,
    input  logic            acc_en,
    input  logic            acc_wr,
    input  logic [XLEN-1:0] acc_addr,
    input  logic [XLEN-1:0] acc_wdata,
    output logic [XLEN-1:0] acc_rdata
);
    logic [XLEN-1:0] mem_d [DEPTH];
    logic [XLEN-1:0] mem_q [DEPTH];
    logic            acc_in_range;
    logic            boot_in_range;

    assign acc_in_range  = acc_addr  < XLEN'(DEPTH);
    assign boot_in_range = boot_addr < XLEN'(DEPTH);

    always_comb begin
        for (int i = 0; i < DEPTH; i++) begin
            mem_d[i] = mem_q[i];
        end
        if (!rst_n) begin
            if (boot_we && boot_in_range) begin
                mem_d[boot_addr[AW-1:0]] = boot_data;
            end
        end else if (acc_en && acc_wr && acc_in_range) begin
            mem_d[acc_addr[AW-1:0]] = acc_wdata;
        end
    end

    always_ff @(posedge clk) begin
        for (int i = 0; i < DEPTH; i++) begin
            mem_q[i] <= mem_d[i];
        end
    end

    assign acc_rdata = (acc_en && !acc_wr && acc_in_range) ? mem_q[acc_addr[AW-1:0]] : '0;
endmodule

// File: rtl/pipe5_core.sv
`timescale 1ns/1ps
module pipe5_core
    import pipe5_pkg::*;
#(
    parameter int IMEM_DEPTH = 64,
    parameter int DMEM_DEPTH = 64
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            boot_we,
    input  logic            boot_dmem,
    input  logic [XLEN-1:0] boot_addr,
    input  logic [XLEN-1:0] boot_data,
    input  logic [RIDW-1:0] dbg_addr,
    output logic [XLEN-1:0] dbg_data,
    output logic            halted
);
    localparam int NREG = 1 << RIDW;
    localparam int IAW  = (IMEM_DEPTH > 1) ? $clog2(IMEM_DEPTH) : 1;
    localparam logic [ILEN-1:0] NOP_WORD = ILEN'(OP_NOP) << OP_LSB;

    core_state_t     st_d, st_q;
    logic [ILEN-1:0] imem_d [IMEM_DEPTH];
    logic [ILEN-1:0] imem_q [IMEM_DEPTH];

    logic [ILEN-1:0] fetch_word;
    logic            fetch_is_halt;
    logic [OPW-1:0]  dec_op;
    logic [XLEN-1:0] rf_a_data, rf_b_data;
    logic [XLEN-1:0] dec_off;
    logic            ex_is_mem;
    logic [XLEN-1:0] alu_b, alu_y;
    logic            dm_en, dm_wr;
    logic [XLEN-1:0] dm_rdata;
    logic            wb_we;
    logic [RIDW-1:0] wb_addr;
    logic [XLEN-1:0] wb_data;

    // ---------------- instruction array (load port only during reset)
    always_comb begin
        for (int i = 0; i < IMEM_DEPTH; i++) begin
            imem_d[i] = imem_q[i];
        end
        if (!rst_n && boot_we && !boot_dmem && (boot_addr < XLEN'(IMEM_DEPTH))) begin
            imem_d[boot_addr[IAW-1:0]] = boot_data;
        end
    end

    always_ff @(posedge clk) begin
        for (int i = 0; i < IMEM_DEPTH; i++) begin
            imem_q[i] <= imem_d[i];
        end
    end

    // ---------------- stage helpers
    assign fetch_word    = (st_q.pc < PCW'(IMEM_DEPTH)) ? imem_q[st_q.pc[IAW-1:0]] : NOP_WORD;
    assign fetch_is_halt = (eff_op(fetch_word) == OP_HALT);

    assign dec_op  = eff_op(st_q.fd.instr);
    assign dec_off = {{(XLEN-OFFW){st_q.fd.instr[OFFW-1]}}, st_q.fd.instr[OFFW-1:0]};

    assign ex_is_mem = (st_q.dx.op == OP_LW) || (st_q.dx.op == OP_SW);
    assign alu_b     = ex_is_mem ? st_q.dx.off : st_q.dx.vb;

    assign dm_en = (st_q.xm.op == OP_LW) || (st_q.xm.op == OP_SW);
    assign dm_wr = (st_q.xm.op == OP_SW);

    assign wb_we   = (st_q.mw.op == OP_ADD) || (st_q.mw.op == OP_NAND) || (st_q.mw.op == OP_LW);
    assign wb_addr = (st_q.mw.op == OP_LW) ? st_q.mw.dst_ld : st_q.mw.dst_rr;
    assign wb_data = (st_q.mw.op == OP_LW) ? st_q.mw.mdata : st_q.mw.alu;

    pipe5_regfile #(
        .XLEN (XLEN),
        .NREG (NREG)
    ) u_regfile (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd_a_addr (st_q.fd.instr[RA_LSB +: RIDW]),
        .rd_a_data (rf_a_data),
        .rd_b_addr (st_q.fd.instr[RB_LSB +: RIDW]),
        .rd_b_data (rf_b_data),
        .wr_en     (wb_we),
        .wr_addr   (wb_addr),
        .wr_data   (wb_data),
        .dbg_addr  (dbg_addr),
        .dbg_data  (dbg_data)
    );

    pipe5_alu #(
        .W (XLEN)
    ) u_alu (
        .op  (st_q.dx.op),
        .opa (st_q.dx.va),
        .opb (alu_b),
        .res (alu_y)
    );

    pipe5_dmem #(
        .XLEN  (XLEN),
        .DEPTH (DMEM_DEPTH)
    ) u_dmem (
        .clk       (clk),
        .rst_n     (rst_n),
        .boot_we   (boot_we && boot_dmem),
        .boot_addr (boot_addr),
        .boot_data (boot_data),
        .acc_en    (dm_en),
        .acc_wr    (dm_wr),
        .acc_addr  (st_q.xm.alu),
        .acc_wdata (st_q.xm.vb),
        .acc_rdata (dm_rdata)
    );

    // ---------------- next-state computation
    always_comb begin
        st_d = st_q;

        // fetch
        if (st_q.halt_seen) begin
            st_d.fd.instr = NOP_WORD;
            st_d.fd.pc1   = st_q.pc;
        end else begin
            st_d.fd.instr = fetch_word;
            st_d.fd.pc1   = st_q.pc + 1'b1;
            if (fetch_is_halt) begin
                st_d.halt_seen = 1'b1;
            end else begin
                st_d.pc = st_q.pc + 1'b1;
            end
        end

        // decode and register read
        st_d.dx.op     = dec_op;
        st_d.dx.va     = rf_a_data;
        st_d.dx.vb     = rf_b_data;
        st_d.dx.off    = dec_off;
        st_d.dx.dst_rr = st_q.fd.instr[RD_LSB +: RIDW];
        st_d.dx.dst_ld = st_q.fd.instr[RB_LSB +: RIDW];
        st_d.dx.pc1    = st_q.fd.pc1;

        // execute
        st_d.xm.op     = st_q.dx.op;
        st_d.xm.alu    = alu_y;
        st_d.xm.vb     = st_q.dx.vb;
        st_d.xm.target = st_q.dx.pc1 + st_q.dx.off[PCW-1:0];
        st_d.xm.dst_rr = st_q.dx.dst_rr;
        st_d.xm.dst_ld = st_q.dx.dst_ld;

        // memory access
        st_d.mw.op     = st_q.xm.op;
        st_d.mw.alu    = st_q.xm.alu;
        st_d.mw.mdata  = dm_rdata;
        st_d.mw.dst_rr = st_q.xm.dst_rr;
        st_d.mw.dst_ld = st_q.xm.dst_ld;

        // drain status: halt leaves writeback with every older word retired
        if (st_q.mw.op == OP_HALT) begin
            st_d.halted = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign halted = st_q.halted;

    // ---------------- assertions
    p_pc_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!st_q.halt_seen && !fetch_is_halt) |=> (st_q.pc == $past(st_q.pc) + 1'b1));

    p_pc_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.halt_seen |=> $stable(st_q.pc));

    p_halted_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.halted |=> st_q.halted);

    p_store_no_rf_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.mw.op == OP_SW) |-> !wb_we);

    p_load_dest_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.mw.op == OP_LW) |-> (wb_we && wb_addr == st_q.mw.dst_ld));

    p_target_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.dx.op != OP_NOP) |=> (st_q.xm.target == $past(st_q.dx.pc1) + $past(st_q.dx.off[PCW-1:0])));
endmodule

// File: tb/pipe5_core_bench.sv
`timescale 1ns/1ps
module pipe5_core_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        boot_we = 1'b0;
    logic        boot_dmem = 1'b0;
    logic [31:0] boot_addr = '0;
    logic [31:0] boot_data = '0;
    logic [2:0]  dbg_addr = '0;
    logic [31:0] dbg_data;
    logic        halted;

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;

    logic [31:0] prog [$];
    logic [31:0] m_mem [64];
    logic [31:0] m_rf [8];
    logic [31:0] got [8];
    logic [31:0] hist [64][8];
    int          wr_e [$];
    int          wr_r [$];
    logic [31:0] wr_v [$];
    int          halt_idx;

    always #2.5 clk = ~clk;

    pipe5_core u_pipe5_core (
        .clk       (clk),
        .rst_n     (rst_n),
        .boot_we   (boot_we),
        .boot_dmem (boot_dmem),
        .boot_addr (boot_addr),
        .boot_data (boot_data),
        .dbg_addr  (dbg_addr),
        .dbg_data  (dbg_data),
        .halted    (halted)
    );

    function automatic logic [31:0] enc_r(int op, int a, int b, int d);
        return (32'(op) << 22) | (32'(a) << 19) | (32'(b) << 16) | 32'(d);
    endfunction

    function automatic logic [31:0] enc_m(int op, int a, int b, int off);
        return (32'(op) << 22) | (32'(a) << 19) | (32'(b) << 16) | (32'(off) & 32'h0000_FFFF);
    endfunction

    localparam logic [31:0] W_NOP  = 32'(7) << 22;
    localparam logic [31:0] W_HALT = 32'(6) << 22;

    task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic boot_word(bit to_d, int addr, logic [31:0] data);
        @(negedge clk);
        boot_we   = 1'b1;
        boot_dmem = to_d;
        boot_addr = 32'(addr);
        boot_data = data;
        if (rst_n == 1'b0 && to_d && addr < 64) m_mem[addr] = data;
        @(negedge clk);
        boot_we = 1'b0;
    endtask

    task automatic read_regs();
        for (int r = 0; r < 8; r++) begin
            dbg_addr = 3'(r);
            #0.1;
            got[r] = dbg_data;
        end
    endtask

    // Sequential interpretation: hazard-free programs retire in order, one per edge.
    task automatic model_program();
        logic [31:0] s [8];
        int idx;
        for (int r = 0; r < 8; r++) s[r] = '0;
        wr_e.delete(); wr_r.delete(); wr_v.delete();
        idx = 0;
        forever begin
            logic [31:0] w, offx, adr, val;
            int op, a, b, d;
            w = (idx < prog.size()) ? prog[idx] : W_NOP;
            op = int'(w[24:22]); a = int'(w[21:19]); b = int'(w[18:16]); d = int'(w[2:0]);
            offx = {{16{w[15]}}, w[15:0]};
            if (w[31:25] != 0) op = 7;
            if (op == 6) begin
                halt_idx = idx;
                break;
            end
            if (op == 0 || op == 1) begin
                val = (op == 0) ? s[a] + s[b] : ~(s[a] & s[b]);
                if (d != 0) begin
                    s[d] = val;
                    wr_e.push_back(idx + 5); wr_r.push_back(d); wr_v.push_back(val);
                end
            end else if (op == 2) begin
                adr = s[a] + offx;
                val = (adr < 64) ? m_mem[adr[5:0]] : 32'h0;
                if (b != 0) begin
                    s[b] = val;
                    wr_e.push_back(idx + 5); wr_r.push_back(b); wr_v.push_back(val);
                end
            end else if (op == 3) begin
                adr = s[a] + offx;
                if (adr < 64) m_mem[adr[5:0]] = s[b];
            end
            idx++;
        end
    endtask

    task automatic run_program();
        for (int i = 0; i < prog.size(); i++) boot_word(1'b0, i, prog[i]);
        model_program();
        for (int r = 0; r < 8; r++) m_rf[r] = '0;
        read_regs();
        for (int r = 0; r < 8; r++) chk("R1", $sformatf("reg %0d during reset", r), got[r], 32'h0);
        chk("R1", "halted during reset", 32'(halted), 32'h0);
        @(negedge clk);
        rst_n = 1'b1;
        #0.5;
        read_regs();
        for (int r = 0; r < 8; r++) chk("R1", $sformatf("reg %0d after release", r), got[r], 32'h0);
        for (int e = 1; e <= halt_idx + 8; e++) begin
            @(posedge clk);
            for (int k = 0; k < wr_e.size(); k++) begin
                if (wr_e[k] == e) m_rf[wr_r[k]] = wr_v[k];
            end
            @(negedge clk);
            read_regs();
            for (int r = 0; r < 8; r++) begin
                hist[e][r] = got[r];
                chk("R8", $sformatf("edge %0d reg %0d", e, r), got[r], m_rf[r]);
            end
            chk("R9", $sformatf("halted after edge %0d", e), 32'(halted), 32'(e >= halt_idx + 5));
        end
    endtask

    initial begin
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        for (int i = 0; i < 64; i++) m_mem[i] = 'x;
        boot_word(1'b1, 0, 32'd9);
        boot_word(1'b1, 1, 32'd12);
        boot_word(1'b1, 2, 32'hFFFF_FFFD);
        boot_word(1'b1, 3, 32'h0F0F_00FF);
        boot_word(1'b1, 10, 32'h55);
        boot_word(1'b1, 29, 32'h0);

        // ---- program one
        prog.delete();
        prog.push_back(enc_m(2, 0, 1, 0));
        prog.push_back(enc_m(2, 0, 2, 1));
        prog.push_back(enc_m(2, 0, 3, 2));
        prog.push_back(enc_m(2, 0, 4, 3));
        prog.push_back(enc_r(0, 1, 2, 5));
        prog.push_back(W_NOP);
        prog.push_back(enc_r(1, 3, 4, 6));
        prog.push_back(enc_m(3, 1, 5, 20));
        prog.push_back(enc_m(2, 2, 7, -2));
        prog.push_back(enc_r(0, 1, 2, 0));
        prog.push_back(W_NOP);
        prog.push_back(enc_m(2, 0, 3, 29));
        prog.push_back(enc_m(3, 0, 6, 100));
        prog.push_back(enc_m(2, 0, 1, 100));
        prog.push_back(enc_r(0, 0, 7, 2));
        prog.push_back(32'h8000_0000 | enc_r(0, 1, 1, 4));
        prog.push_back(enc_r(5, 1, 1, 4));
        prog.push_back(W_HALT);
        prog.push_back(enc_r(0, 5, 5, 4));
        run_program();
        chk("R8", "r1 one edge before retire", hist[4][1], 32'h0);
        chk("R8", "r1 at retire edge", hist[5][1], 32'd9);
        chk("R2", "r5 add", got[5], 32'd21);
        chk("R7", "r5 used same-cycle r2", got[5], 32'd21);
        chk("R3", "r6 nand", got[6], 32'hF0F0_FF02);
        chk("R4", "r7 load with negative offset", got[7], 32'h55);
        chk("R5", "r3 reload of stored word", got[3], 32'd21);
        chk("R6", "r0 after add to r0", got[0], 32'h0);
        chk("R6", "r2 add reads zero r0", got[2], 32'h55);
        chk("R11", "r1 out-of-range load", got[1], 32'h0);
        chk("R12", "r4 untouched by reserved words", got[4], 32'h0F0F_00FF);
        chk("R9", "r4 untouched by word after halt", got[4], 32'h0F0F_00FF);

        // ---- load port while running must be ignored
        boot_word(1'b1, 0, 32'hDEAD_BEEF);
        chk("R10", "halted unchanged by run-time load", 32'(halted), 32'h1);
        @(negedge clk);
        rst_n = 1'b0;

        // ---- program two
        prog.delete();
        prog.push_back(enc_m(2, 0, 0, 0));
        prog.push_back(enc_m(2, 0, 1, 0));
        prog.push_back(enc_m(2, 0, 2, 3));
        prog.push_back(W_NOP);
        prog.push_back(W_NOP);
        prog.push_back(enc_r(1, 1, 2, 3));
        prog.push_back(enc_r(1, 2, 2, 4));
        prog.push_back(W_NOP);
        prog.push_back(enc_r(0, 3, 1, 5));
        prog.push_back(enc_r(1, 0, 0, 6));
        prog.push_back(enc_r(0, 4, 4, 7));
        prog.push_back(W_HALT);
        run_program();
        chk("R6", "r0 after load to r0", got[0], 32'h0);
        chk("R10", "r1 loads word unchanged by run-time load", got[1], 32'd9);
        chk("R4", "r2 load", got[2], 32'h0F0F_00FF);
        chk("R3", "r3 nand", got[3], 32'hFFFF_FFF6);
        chk("R3", "r4 nand self", got[4], 32'hF0F0_FF00);
        chk("R2", "r5 add", got[5], 32'hFFFF_FFFF);
        chk("R3", "r6 nand of zeros", got[6], 32'hFFFF_FFFF);
        chk("R2", "r7 add wraps", got[7], 32'hE1E1_FE00);

        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(200000 * 5.0);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL R9 watchdog: actual=timeout expected=completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule